// File: doc/BRIEF.md
# Timer channel capture/compare status flags

One timer channel with a free-running up-counter and two or three general registers (A, B and, optionally, C). Each general register works either as an output-compare register, whose flag rises when the counter equals it, or as an input-capture register, which copies the counter when an edge of the chosen polarity arrives on its capture pin. Each register has a status flag that drives an interrupt request through a per-flag enable.

Software clears a flag with a two-step sequence. It first reads the flag register while the flag is 1, which arms that flag. It then writes 0 to the flag's bit. A transfer controller can also clear a flag by acknowledging its request, unless the acknowledge carries the keep-flag bit. When a new event arrives in the same cycle as a clear, the event wins. The parameter `HAS_C` decides whether register C and its flag are built.

Top module: `tmr_chan_flags`

## Requirements
- R1: After reset the flags, the interrupt enables, the counter and the mode register are all 0. All registers are then in capture mode with no edge selected, and `irq_o` is 0.
- R2: A register in compare mode (mode bit i = 1) sets its flag at the clock edge that ends the cycle in which the counter equals the register.
- R3: A register in capture mode takes its edge select from mode bits [4+2i:3+2i]: 00 none, 01 rising, 10 falling, 11 both. The pin passes through two flip-flops. The counter value from the cycle after the second synchronizer stage changes is copied into the register, and the flag is set at the same edge.
- R4: Writing 1 to a flag bit has no effect on that flag.
- R5: A read of the flag register arms each flag that reads as 1. A later write of 0 clears only the armed flags. An unarmed flag stays set.
- R6: A flag's arm is dropped when the flag clears. After it sets again, a write of 0 without a new read leaves it set.
- R7: `xfer_ack_i[i]` clears flag i when `xfer_noclr_i` is 0. When `xfer_noclr_i` is 1 the flag stays set.
- R8: A set condition in the same cycle as a clear request leaves the flag at 1.
- R9: `irq_o[i]` is flag i ANDed with enable bit i of the enable register.
- R10: With `HAS_C`=0, flag bit 2 reads 0 and ignores writes and captures, `irq_o[2]` is 0, and general register C reads 0.
- R11: Bus map. Address 0 is the counter (writing loads it). Address 1 is mode, with bits [2:0] compare-select and then the edge fields. Address 2 is the interrupt enables [2:0]. Address 3 is the flags [2:0]. Addresses 4, 5 and 6 are registers A, B and C. Read data is combinational while `bus_rd_i` is high, and writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (arms flags read as 1) |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data |
| cap_i | input | 3 | Capture pins for A, B, C |
| xfer_ack_i | input | 3 | Transfer-controller acknowledge per flag |
| xfer_noclr_i | input | 1 | Keep-flag bit of the acknowledged transfer |
| irq_o | output | 3 | Interrupt requests |

## Verification
On every cycle the assertions check four things. A compare match always leaves its flag set. A flag falls only after an armed zero write or an acknowledge without the keep bit. Writes of 1, unarmed zero writes and keep-flag acknowledges leave a set flag alone. A request is never raised while its enable is off. Only the bench scenarios show the capture edge polarities, the exact captured counter value and the compare timing. They also show the arm sequence across several flags, the loss of the arm after a clear, and the behaviour of the channel built without register C.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] ADR_CNT  = 3'd0;
  localparam logic [2:0] ADR_MODE = 3'd1;
  localparam logic [2:0] ADR_IEN  = 3'd2;
  localparam logic [2:0] ADR_FLG  = 3'd3;
  localparam logic [2:0] ADR_GRA  = 3'd4;
  localparam int unsigned GR_MAX  = 3;
  localparam int unsigned MODE_W  = GR_MAX * 3;
endpackage

// File: rtl/tmr_cap_sync.sv
module tmr_cap_sync (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] edge_sel_i,
  output logic       edge_o
);
  logic s1_q, s2_q, prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0; s2_q <= 1'b0; prev_q <= 1'b0;
    end else begin
      s1_q <= pin_i; s2_q <= s1_q; prev_q <= s2_q;
    end
  end
  assign edge_o = (edge_sel_i[0] & s2_q & ~prev_q) | (edge_sel_i[1] & ~s2_q & prev_q);
endmodule

// File: rtl/tmr_flag_slice.sv
module tmr_flag_slice #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cmp_mode_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             cap_pin_i,
  input  logic             gr_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             flag_rd_i,
  input  logic             flag_wr_i,
  input  logic             flag_wbit_i,
  input  logic             ack_i,
  input  logic             noclr_i,
  output logic [CNT_W-1:0] gr_o,
  output logic             flag_o,
  output logic             arm_o
);
  logic cap_edge, set_evt, clr_req, flag_d;
  logic [CNT_W-1:0] gr_q;
  logic flag_q, arm_q;

  tmr_cap_sync u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(cap_pin_i),
    .edge_sel_i(edge_sel_i), .edge_o(cap_edge)
  );

  assign set_evt = cmp_mode_i ? (cnt_i == gr_q) : cap_edge;
  assign clr_req = (flag_wr_i & ~flag_wbit_i & arm_q) | (ack_i & ~noclr_i);
  // event beats clear so nothing is lost
  assign flag_d  = set_evt | (flag_q & ~clr_req);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gr_q <= '0; flag_q <= 1'b0; arm_q <= 1'b0;
    end else begin
      if (!cmp_mode_i && cap_edge) gr_q <= cnt_i;
      else if (gr_we_i)            gr_q <= wdata_i;
      flag_q <= flag_d;
      if (flag_q && !flag_d)         arm_q <= 1'b0;
      else if (flag_rd_i && flag_q)  arm_q <= 1'b1;
    end
  end

  assign gr_o   = gr_q;
  assign flag_o = flag_q;
  assign arm_o  = arm_q;
endmodule

// File: rtl/tmr_chan_flags.sv
module tmr_chan_flags
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter bit          HAS_C = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       bus_addr_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [CNT_W-1:0] bus_wdata_i,
  output logic [CNT_W-1:0] bus_rdata_o,
  input  logic [2:0]       cap_i,
  input  logic [2:0]       xfer_ack_i,
  input  logic             xfer_noclr_i,
  output logic [2:0]       irq_o
);
  localparam int unsigned NREG = HAS_C ? 3 : 2;

  logic [CNT_W-1:0]          cnt_q;
  logic [MODE_W-1:0]         mode_q;
  logic [GR_MAX-1:0]         ien_q;
  logic [GR_MAX-1:0]         flag_q, arm;
  logic [GR_MAX-1:0][CNT_W-1:0] gr;
  logic wr_flg, rd_flg;

  assign wr_flg = bus_wr_i && (bus_addr_i == ADR_FLG);
  assign rd_flg = bus_rd_i && (bus_addr_i == ADR_FLG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; mode_q <= '0; ien_q <= '0;
    end else begin
      if (bus_wr_i && bus_addr_i == ADR_CNT) cnt_q <= bus_wdata_i;
      else                                   cnt_q <= cnt_q + 1'b1;
      if (bus_wr_i && bus_addr_i == ADR_MODE) mode_q <= bus_wdata_i[MODE_W-1:0];
      if (bus_wr_i && bus_addr_i == ADR_IEN)  ien_q  <= bus_wdata_i[GR_MAX-1:0];
    end
  end

  for (genvar i = 0; i < GR_MAX; i++) begin : g_gr
    if (i < NREG) begin : g_on
      tmr_flag_slice #(.CNT_W(CNT_W)) u_slice (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cnt_i      (cnt_q),
        .cmp_mode_i (mode_q[i]),
        .edge_sel_i (mode_q[GR_MAX+2*i +: 2]),
        .cap_pin_i  (cap_i[i]),
        .gr_we_i    (bus_wr_i && bus_addr_i == ADR_GRA + 3'(i)),
        .wdata_i    (bus_wdata_i),
        .flag_rd_i  (rd_flg),
        .flag_wr_i  (wr_flg),
        .flag_wbit_i(bus_wdata_i[i]),
        .ack_i      (xfer_ack_i[i]),
        .noclr_i    (xfer_noclr_i),
        .gr_o       (gr[i]),
        .flag_o     (flag_q[i]),
        .arm_o      (arm[i])
      );
    end else begin : g_off
      assign gr[i]     = '0;
      assign flag_q[i] = 1'b0;
      assign arm[i]    = 1'b0;
    end
  end

  assign irq_o = flag_q & ien_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i) begin
      case (bus_addr_i)
        ADR_CNT:  bus_rdata_o = cnt_q;
        ADR_MODE: bus_rdata_o[MODE_W-1:0] = mode_q;
        ADR_IEN:  bus_rdata_o[GR_MAX-1:0] = ien_q;
        ADR_FLG:  bus_rdata_o[GR_MAX-1:0] = flag_q;
        3'd4:     bus_rdata_o = gr[0];
        3'd5:     bus_rdata_o = gr[1];
        3'd6:     bus_rdata_o = gr[2];
        default:  bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_chan_flags_chk.sv
module tmr_chan_flags_chk
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter bit          HAS_C = 1'b1
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [2:0]                bus_addr_i,
  input logic                      bus_wr_i,
  input logic [CNT_W-1:0]          bus_wdata_i,
  input logic [2:0]                xfer_ack_i,
  input logic                      xfer_noclr_i,
  input logic [2:0]                irq_o,
  input logic [2:0]                ien_i,
  input logic [2:0]                flag_i,
  input logic [2:0]                arm_i,
  input logic [2:0]                cmp_i,
  input logic [CNT_W-1:0]          cnt_i,
  input logic [2:0][CNT_W-1:0]     gr_i
);
  localparam int unsigned NREG = HAS_C ? 3 : 2;

  for (genvar i = 0; i < NREG; i++) begin : g_a
    // R2, R8
    a_r2_cmp_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_i[i] && cnt_i == gr_i[i]) |=> flag_i[i]);
    // R5, R7
    a_r5_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_i[i]) |-> $past((bus_wr_i && bus_addr_i == ADR_FLG && !bus_wdata_i[i] && arm_i[i])
                                 || (xfer_ack_i[i] && !xfer_noclr_i)));
    a_r4_one_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_i[i] && bus_wr_i && bus_addr_i == ADR_FLG && bus_wdata_i[i] && !xfer_ack_i[i]) |=> flag_i[i]);
    a_r5_unarmed_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_i[i] && !arm_i[i] && !xfer_ack_i[i]) |=> flag_i[i]);
    a_r7_noclr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_i[i] && xfer_ack_i[i] && xfer_noclr_i && !(bus_wr_i && bus_addr_i == ADR_FLG)) |=> flag_i[i]);
  end

  for (genvar i = 0; i < 3; i++) begin : g_irq
    a_r9_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[i] |-> (ien_i[i] && flag_i[i]));
  end
endmodule

bind tmr_chan_flags tmr_chan_flags_chk #(.CNT_W(CNT_W), .HAS_C(HAS_C)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
  .bus_wdata_i(bus_wdata_i), .xfer_ack_i(xfer_ack_i), .xfer_noclr_i(xfer_noclr_i),
  .irq_o(irq_o), .ien_i(ien_q), .flag_i(flag_q), .arm_i(arm), .cmp_i(mode_q[2:0]),
  .cnt_i(cnt_q), .gr_i(gr)
);

// File: tb/tmr_chan_flags_bench.sv
`timescale 1ns/1ps
module tmr_chan_flags_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, rdata_nc;
  logic [2:0] cap = '0, ack = '0, irq, irq_nc;
  logic noclr = 1'b0;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_chan_flags #(.CNT_W(16), .HAS_C(1'b1)) u_tmr_chan_flags (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cap_i(cap), .xfer_ack_i(ack),
    .xfer_noclr_i(noclr), .irq_o(irq));

  tmr_chan_flags #(.CNT_W(16), .HAS_C(1'b0)) u_nc (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata_nc), .cap_i(cap), .xfer_ack_i(ack),
    .xfer_noclr_i(noclr), .irq_o(irq_nc));

  // {edge_sel[1:0], start_level, expect_flag}
  localparam logic [3:0] VEC [8] = '{
    4'b00_0_0, 4'b00_1_0, 4'b01_0_1, 4'b01_1_0,
    4'b10_0_0, 4'b10_1_1, 4'b11_0_1, 4'b11_1_1};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d, output logic [15:0] dn);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata; dn = rdata_nc;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    logic [15:0] d, dn;
    bus_rd(tmr_pkg::ADR_FLG, d, dn);
    bus_wr(tmr_pkg::ADR_FLG, 16'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] d, dn;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1
    bus_rd(tmr_pkg::ADR_FLG, d, dn);  chk("R1 flags", d, 0);
    bus_rd(tmr_pkg::ADR_MODE, d, dn); chk("R1 mode", d, 0);
    bus_rd(tmr_pkg::ADR_IEN, d, dn);  chk("R1 ien", d, 0);
    chk("R1 irq", irq, 0);

    // R3 edge polarity table on register B
    for (int v = 0; v < 8; v++) begin
      bus_wr(tmr_pkg::ADR_MODE, 16'h0);
      cap[1] = VEC[v][1];
      wait_n(5);
      clear_all();
      bus_wr(tmr_pkg::ADR_MODE, 16'(VEC[v][3:2]) << 5);
      cap[1] = ~VEC[v][1];
      wait_n(6);
      bus_rd(tmr_pkg::ADR_FLG, d, dn);
      chk($sformatf("R3 edge vec %0d", v), d[1], VEC[v][0]);
    end
    bus_wr(tmr_pkg::ADR_MODE, 16'h0);
    wait_n(4);
    clear_all();

    // R3 captured value, A rising
    bus_wr(tmr_pkg::ADR_IEN, 16'h7);
    bus_wr(tmr_pkg::ADR_MODE, 16'h0008);
    bus_wr(tmr_pkg::ADR_CNT, 16'd100);
    cap[0] = 1'b1;
    wait_n(4);
    chk("R9 irq follows flag", irq, 3'b001);
    bus_wr(tmr_pkg::ADR_FLG, 16'h0);
    chk("R5 unarmed zero write keeps flag", irq[0], 1);
    bus_wr(tmr_pkg::ADR_FLG, 16'h7);
    chk("R4 write one no effect", irq[0], 1);
    bus_rd(3'd4, d, dn);
    chk("R3 capture value", d, 102);
    bus_rd(tmr_pkg::ADR_FLG, d, dn);
    chk("R5 flag reads 1", d[0], 1);
    bus_wr(tmr_pkg::ADR_FLG, 16'h0);
    chk("R5 armed zero write clears", irq[0], 0);

    // R6 arm dropped
    cap[0] = 1'b0; wait_n(4);
    cap[0] = 1'b1; wait_n(5);
    chk("R6 flag set again", irq[0], 1);
    bus_wr(tmr_pkg::ADR_FLG, 16'h0);
    chk("R6 arm dropped after clear", irq[0], 1);

    // R5 per-flag arming
    bus_rd(tmr_pkg::ADR_FLG, d, dn);
    bus_wr(tmr_pkg::ADR_MODE, 16'h0028);
    cap[1] = 1'b0; wait_n(4);
    cap[1] = 1'b1; wait_n(5);
    chk("R5 both set", irq, 3'b011);
    bus_wr(tmr_pkg::ADR_FLG, 16'h0);
    chk("R5 only armed flag clears", irq, 3'b010);

    // R7 transfer acknowledge
    @(negedge clk); ack[1] = 1'b1; noclr = 1'b1;
    @(negedge clk); ack[1] = 1'b0; noclr = 1'b0;
    chk("R7 keep bit holds flag", irq[1], 1);
    @(negedge clk); ack[1] = 1'b1;
    @(negedge clk); ack[1] = 1'b0;
    chk("R7 ack clears flag", irq[1], 0);

    // R9 enable gating
    cap[0] = 1'b0; wait_n(4);
    cap[0] = 1'b1; wait_n(5);
    bus_wr(tmr_pkg::ADR_IEN, 16'h6);
    chk("R9 disabled irq low", irq[0], 0);
    bus_rd(tmr_pkg::ADR_FLG, d, dn);
    chk("R9 flag still set", d[0], 1);
    bus_wr(tmr_pkg::ADR_IEN, 16'h7);

    // R2 compare on A
    bus_wr(tmr_pkg::ADR_CNT, 16'd0);
    bus_wr(3'd4, 16'd203);
    bus_wr(tmr_pkg::ADR_MODE, 16'h0001);
    clear_all();
    chk("R2 cleared before match", irq[0], 0);
    bus_wr(tmr_pkg::ADR_CNT, 16'd200);
    wait_n(3);
    chk("R2 no flag before match", irq[0], 0);
    wait_n(1);
    chk("R2 flag after match", irq[0], 1);

    // R8 set beats clear (flag already 1, unarmed, acknowledge in match cycle)
    bus_wr(tmr_pkg::ADR_CNT, 16'd200);
    wait_n(3);
    ack[0] = 1'b1;
    wait_n(1);
    ack[0] = 1'b0;
    chk("R8 set wins over ack", irq[0], 1);
    @(negedge clk); ack[0] = 1'b1;
    @(negedge clk); ack[0] = 1'b0;
    chk("R8 plain ack clears", irq[0], 0);

    // R10 channel without C, R11 register C access
    bus_wr(tmr_pkg::ADR_MODE, 16'h0180);
    cap[2] = 1'b1; wait_n(5);
    cap[2] = 1'b0; wait_n(5);
    bus_wr(tmr_pkg::ADR_FLG, 16'h7);
    bus_rd(tmr_pkg::ADR_FLG, d, dn);
    chk("R10 C flag reads 0", dn[2], 0);
    chk("R11 C flag set on full channel", d[2], 1);
    chk("R10 irq C low", irq_nc[2], 0);
    bus_wr(tmr_pkg::ADR_MODE, 16'h0);
    bus_wr(3'd6, 16'h1234);
    bus_rd(3'd6, d, dn);
    chk("R10 GR C reads 0", dn, 0);
    chk("R11 GR C write", d, 16'h1234);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule